// File: doc/BRIEF.md
# Serial Channel Status and Error Flag Unit

This block keeps the buffer status and the error flags of a serial channel that runs either as an asynchronous UART or as a clocked synchronous I/O port. The receive and transmit datapaths report single-cycle event strobes to it. These strobes mark a frame finishing, a frame entering the receive buffer, the transmit buffer being handed to the shift register, the shifter asking for its next word, a parity mismatch and a missing stop bit. The bus side reports reads of the receive buffer, writes of the transmit buffer and reads of the control register. All flags are registered, so an event shows at the outputs one clock after the edge that samples it.

The three error flags change meaning with the operating mode. In UART mode they report overrun, parity error and framing error. With an external serial clock, the second flag reports transmit underrun, and only when double buffering and the FIFO are both on. With an internally generated clock, an overrun also raises a request that stops the serial clock until software reads the control register. Any read of the control register clears every error flag, but an error that arrives in the same cycle as the read is kept.

Top module: `sio_flag_unit`

## Requirements
- R1: After reset the receive-full flag, all three error flags and the clock-stop request are 0, and the internal transmit-empty state is 1 (so `tx_empty_o` is 1 when `dbuf_en_i` is 1).
- R2: `rx_full_o` and `tx_empty_o` read 0 whenever `dbuf_en_i` is 0, while the underlying state keeps tracking events.
- R3: The receive-full state sets one cycle after `rx_to_buf_i` and clears one cycle after `rd_rxbuf_i`. When both occur together the set wins.
- R4: The transmit-empty state sets one cycle after `tx_load_i` and clears one cycle after `wr_txbuf_i`. When both occur together the write wins and the state becomes 0.
- R5: With `fifo_en_i`=0, `rx_done_i` while the receive-full state is 1 sets the overrun flag, in every mode.
- R6: With `fifo_en_i`=1, `rx_done_i` sets the overrun flag only when `fifo_full_i` is 1, whatever the receive-full state.
- R7: With mode 2'b00 (UART; 2'b11 behaves the same), `rx_done_i` together with `par_err_i` sets the second error flag, and `rx_done_i` together with `stop_err_i` sets the framing flag.
- R8: With mode 2'b01 (I/O, external clock), `tx_need_i` while the transmit-empty state is 1 sets the second flag (underrun), but only if `dbuf_en_i` and `fifo_en_i` are both 1. Otherwise that flag reads 0.
- R9: The framing flag reads 0 in modes 2'b01 and 2'b10, and the second flag reads 0 in mode 2'b10 (I/O, internal clock).
- R10: `rd_ctrl_i` clears all three error flags one cycle later. An error event in the same cycle as the read is set instead.
- R11: In mode 2'b10, `sclk_stop_o` is 1 exactly while the overrun flag is 1, so it is released the cycle after the clearing read. In other modes it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 UART, 01 I/O external clock, 10 I/O internal clock, 11 as UART |
| dbuf_en_i | input | 1 | Double buffering enabled |
| fifo_en_i | input | 1 | Receive/transmit FIFO enabled |
| fifo_full_i | input | 1 | Receive FIFO usable depth is full |
| rx_done_i | input | 1 | A receive frame has completed |
| rx_to_buf_i | input | 1 | Received frame moved into the receive buffer |
| par_err_i | input | 1 | Parity mismatch on the completing frame |
| stop_err_i | input | 1 | Missing stop bit on the completing frame |
| tx_load_i | input | 1 | Transmit buffer moved into the shift register |
| tx_need_i | input | 1 | Transmit shifter requests its next word |
| rd_rxbuf_i | input | 1 | Bus read of the receive buffer |
| wr_txbuf_i | input | 1 | Bus write of the transmit buffer |
| rd_ctrl_i | input | 1 | Bus read of the control register |
| rx_full_o | output | 1 | Receive buffer full |
| tx_empty_o | output | 1 | Transmit buffer empty |
| ovr_err_o | output | 1 | Overrun error |
| par_unr_o | output | 1 | Parity error (UART) or underrun (external clock) |
| frm_err_o | output | 1 | Framing error |
| sclk_stop_o | output | 1 | Request to halt the serial clock output |

## Verification
A wrong receive-full or transmit-empty state shows at the ports in two ways. It appears directly on the status outputs one cycle after the event, and it later gives a wrong overrun or underrun flag on the next frame or shifter request. A wrong mode qualification shows as an error flag that rises, or fails to rise, one cycle after the completing frame. A clear or priority fault shows in the cycle right after a control-register read. The clock-stop request is compared on the same cycles, so a missed release is seen within one clock.

// File: rtl/sio_flag_pkg.sv
package sio_flag_pkg;
  localparam int MODE_W = 2;
  localparam int ERR_N  = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_UART = 2'b00,
    MD_EXTC = 2'b01,
    MD_INTC = 2'b10,
    MD_RSVD = 2'b11
  } sio_mode_e;

  // error vector positions
  localparam int E_OVR = 0;
  localparam int E_PAR = 1;
  localparam int E_FRM = 2;
endpackage

// File: rtl/sio_sticky_bit.sv
module sio_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d, q_r;

  always_comb begin
    q_d = q_r;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q_o = q_r;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R10
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/sio_buf_status.sv
module sio_buf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_to_buf_i,
  input  logic rd_rxbuf_i,
  input  logic tx_load_i,
  input  logic wr_txbuf_i,
  output logic rx_full_o,
  output logic tx_empty_o
);
  logic rxf_d, rxf_r, txe_d, txe_r;

  always_comb begin
    rxf_d = rxf_r;
    if (rd_rxbuf_i)  rxf_d = 1'b0;
    if (rx_to_buf_i) rxf_d = 1'b1;
    txe_d = txe_r;
    if (tx_load_i)   txe_d = 1'b1;
    if (wr_txbuf_i)  txe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_r <= 1'b0;
      txe_r <= 1'b1;
    end else begin
      rxf_r <= rxf_d;
      txe_r <= txe_d;
    end
  end

  assign rx_full_o  = rxf_r;
  assign tx_empty_o = txe_r;

  // R3
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_to_buf_i |=> rx_full_o);
  // R3
  rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxbuf_i && !rx_to_buf_i) |=> !rx_full_o);
  // R4
  tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txbuf_i |=> !tx_empty_o);
  // R4
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load_i && !wr_txbuf_i) |=> tx_empty_o);
endmodule

// File: rtl/sio_err_flags.sv
module sio_err_flags
  import sio_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dbuf_en_i,
  input  logic              fifo_en_i,
  input  logic              fifo_full_i,
  input  logic              rx_done_i,
  input  logic              par_err_i,
  input  logic              stop_err_i,
  input  logic              tx_need_i,
  input  logic              rd_ctrl_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  output logic [ERR_N-1:0]  err_o
);
  sio_mode_e  md;
  logic       uart_md, extc_md;
  logic       no_room;
  logic [ERR_N-1:0] set_v;

  always_comb begin
    md      = sio_mode_e'(mode_i);
    uart_md = (md == MD_UART) || (md == MD_RSVD);
    extc_md = (md == MD_EXTC);
    no_room = fifo_en_i ? fifo_full_i : rx_full_i;
    set_v        = '0;
    set_v[E_OVR] = rx_done_i && no_room;
    if (uart_md) begin
      set_v[E_PAR] = rx_done_i && par_err_i;
      set_v[E_FRM] = rx_done_i && stop_err_i;
    end else if (extc_md) begin
      set_v[E_PAR] = tx_need_i && tx_empty_i && dbuf_en_i && fifo_en_i;
    end
  end

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    sio_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[i]),
      .clr_i (rd_ctrl_i),
      .q_o   (err_o[i])
    );
  end

  // R6
  fifo_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_i && !fifo_full_i && !rd_ctrl_i && !err_o[E_OVR]) |=> !err_o[E_OVR]);
endmodule

// File: rtl/sio_flag_unit.sv
module sio_flag_unit
  import sio_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dbuf_en_i,
  input  logic              fifo_en_i,
  input  logic              fifo_full_i,
  input  logic              rx_done_i,
  input  logic              rx_to_buf_i,
  input  logic              par_err_i,
  input  logic              stop_err_i,
  input  logic              tx_load_i,
  input  logic              tx_need_i,
  input  logic              rd_rxbuf_i,
  input  logic              wr_txbuf_i,
  input  logic              rd_ctrl_i,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              ovr_err_o,
  output logic              par_unr_o,
  output logic              frm_err_o,
  output logic              sclk_stop_o
);
  logic rxf, txe;
  logic [ERR_N-1:0] err;
  sio_mode_e md;
  logic par_vis, frm_vis, intc_md;

  sio_buf_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_to_buf_i (rx_to_buf_i),
    .rd_rxbuf_i  (rd_rxbuf_i),
    .tx_load_i   (tx_load_i),
    .wr_txbuf_i  (wr_txbuf_i),
    .rx_full_o   (rxf),
    .tx_empty_o  (txe)
  );

  sio_err_flags u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .dbuf_en_i   (dbuf_en_i),
    .fifo_en_i   (fifo_en_i),
    .fifo_full_i (fifo_full_i),
    .rx_done_i   (rx_done_i),
    .par_err_i   (par_err_i),
    .stop_err_i  (stop_err_i),
    .tx_need_i   (tx_need_i),
    .rd_ctrl_i   (rd_ctrl_i),
    .rx_full_i   (rxf),
    .tx_empty_i  (txe),
    .err_o       (err)
  );

  always_comb begin
    md      = sio_mode_e'(mode_i);
    intc_md = (md == MD_INTC);
    frm_vis = (md == MD_UART) || (md == MD_RSVD);
    par_vis = frm_vis || ((md == MD_EXTC) && dbuf_en_i && fifo_en_i);
  end

  assign rx_full_o   = rxf && dbuf_en_i;
  assign tx_empty_o  = txe && dbuf_en_i;
  assign ovr_err_o   = err[E_OVR];
  assign par_unr_o   = err[E_PAR] && par_vis;
  assign frm_err_o   = err[E_FRM] && frm_vis;
  assign sclk_stop_o = err[E_OVR] && intc_md;

  // R2
  dbuf_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbuf_en_i |-> (!rx_full_o && !tx_empty_o));
  // R9
  frm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 || mode_i == 2'b10) |-> !frm_err_o);
  // R11
  stop_needs_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_stop_o |-> ovr_err_o);
  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl_i && !rx_done_i) |=> !sclk_stop_o);
endmodule

// File: tb/tb_sio_flag_unit.sv
`timescale 1ns/1ps
module tb_sio_flag_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic dbuf, fen, ffull, rxd, rxb, perr, serr, tld, tnd, rrd, twr, crd;
  logic rx_full, tx_empty, ovr, par, frm, stp;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit m_rxf, m_txe, m_ovr, m_par, m_frm;

  always #2.5 clk = ~clk;

  sio_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .dbuf_en_i(dbuf), .fifo_en_i(fen),
    .fifo_full_i(ffull), .rx_done_i(rxd), .rx_to_buf_i(rxb), .par_err_i(perr),
    .stop_err_i(serr), .tx_load_i(tld), .tx_need_i(tnd), .rd_rxbuf_i(rrd),
    .wr_txbuf_i(twr), .rd_ctrl_i(crd), .rx_full_o(rx_full), .tx_empty_o(tx_empty),
    .ovr_err_o(ovr), .par_unr_o(par), .frm_err_o(frm), .sclk_stop_o(stp));

  task automatic chk(string req, logic act, bit exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clr_strobes();
    rxd = 0; rxb = 0; perr = 0; serr = 0; tld = 0; tnd = 0;
    rrd = 0; twr = 0; crd = 0;
  endtask

  task automatic compare_all();
    bit uart, pv;
    uart = (mode == 2'b00) || (mode == 2'b11);
    pv = uart || (mode == 2'b01 && dbuf && fen);
    chk("R2/R3 rx_full", rx_full, m_rxf && dbuf);
    chk("R2/R4 tx_empty", tx_empty, m_txe && dbuf);
    chk("R5/R6 ovr", ovr, m_ovr);
    chk("R7/R8/R9 par_unr", par, m_par && pv);
    chk("R7/R9 frm", frm, m_frm && uart);
    chk("R11 sclk_stop", stp, m_ovr && (mode == 2'b10));
  endtask

  // one clock: model follows the requirements with the driven strobes
  task automatic step();
    bit room_gone, s_ovr, s_par, s_frm, n_rxf, n_txe;
    @(posedge clk);
    room_gone = fen ? ffull : m_rxf;
    s_ovr = rxd && room_gone;
    s_par = 0; s_frm = 0;
    if (mode == 2'b00 || mode == 2'b11) begin
      s_par = rxd && perr; s_frm = rxd && serr;
    end else if (mode == 2'b01) begin
      s_par = tnd && m_txe && dbuf && fen;
    end
    n_rxf = rxb ? 1'b1 : (rrd ? 1'b0 : m_rxf);
    n_txe = twr ? 1'b0 : (tld ? 1'b1 : m_txe);
    m_ovr = s_ovr || (m_ovr && !crd);
    m_par = s_par || (m_par && !crd);
    m_frm = s_frm || (m_frm && !crd);
    m_rxf = n_rxf; m_txe = n_txe;
    @(negedge clk);
    compare_all();
    clr_strobes();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode = 2'b00; dbuf = 1; fen = 0; ffull = 0;
    clr_strobes();
    m_rxf = 0; m_txe = 1; m_ovr = 0; m_par = 0; m_frm = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rx_full", rx_full, 0); chk("R1 tx_empty", tx_empty, 1);
    chk("R1 ovr", ovr, 0); chk("R1 stop", stp, 0);
    rst_n = 1;
    step();
    // R3 fill, drain, and set-wins
    rxb = 1; step();
    rrd = 1; step();
    rxb = 1; rrd = 1; step();
    // R5 overrun with buffer full, no FIFO
    rxd = 1; step();
    // R10 clearing read
    crd = 1; step();
    step();
    // R4 write, load, write-wins
    twr = 1; step();
    tld = 1; step();
    tld = 1; twr = 1; step();
    // R2 masking with double buffer off; state still tracked
    dbuf = 0; tld = 1; step();
    rrd = 1; step();
    dbuf = 1; step();
    // R7 UART parity and framing
    rxd = 1; perr = 1; step();
    rxd = 1; serr = 1; step();
    crd = 1; step();
    // R10 error in same cycle as read is kept
    rxd = 1; perr = 1; crd = 1; step();
    crd = 1; step();
    // R6 FIFO on: no overrun without fifo_full even if buffer full
    fen = 1; rxb = 1; step();
    rxd = 1; step();
    rxd = 1; ffull = 1; step();
    ffull = 0; crd = 1; step();
    rrd = 1; step();
    // R8 underrun with external clock, dbuf+fifo on, tx empty
    mode = 2'b01; tld = 1; step();
    tnd = 1; step();
    // R9 framing reads 0 outside UART
    rxd = 1; serr = 1; step();
    crd = 1; step();
    // R8 no underrun flag when FIFO off
    fen = 0; tnd = 1; step();
    crd = 1; step();
    // R9 internal clock: parity event ignored
    mode = 2'b10; rxd = 1; perr = 1; step();
    // R11 overrun halts clock, released after read
    rxb = 1; step();
    rxd = 1; step();
    step();
    crd = 1; step();
    step();
    // R5 overrun also in external clock mode
    mode = 2'b01; rxd = 1; step();
    crd = 1; rrd = 1; step();
    step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule